// File: doc/BRIEF.md
# Cascaded Reload-Timer Baud Tick Generator

This block is a bank of small down-counting reload timers that makes the bit-rate ticks for two serial channels. One timer serves as a shared prescaler and always counts the I/O clock. The remaining timers each count either the I/O clock directly or the prescaler's underflow pulses. A cascaded timer therefore divides the clock in two stages. Every timer has a one-cycle underflow output. The channel ticks are timer 2 (channel 0) and timer 3 (channel 1).

Software sets the timers up through a byte-wide write port. Each timer has a control byte and a reload byte. Software computes the division ratios itself and writes each ratio minus one as the reload value. When no prescaling is needed, the prescaler is left disabled with a zero reload, and the channel timer counts the clock directly.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset every timer is disabled and all underflow outputs are low.
- R2: The control byte of timer i is written at address 0x00+i and its reload byte at address 0x10+i (5-bit address). A write to any other address changes no timer's behaviour.
- R3: Control bit 7 enables a timer. A disabled timer produces no underflow pulses.
- R4: Control bits [3:2] select the count source: 00 counts every clock, 01 counts the underflow pulses of timer 0, and 10 or 11 count nothing. Timer 0 ignores this field and always counts the clock.
- R5: With reload value N, a timer emits a one-cycle underflow pulse once every N+1 counted events, and reloads on that same event. With the clock as source, the pulse period is N+1 cycles, and N = 0 gives a pulse on every cycle.
- R6: A timer counting timer 0's underflows, with prescaler reload P and its own reload D, pulses every (P+1)*(D+1) clock cycles. If timer 0 is disabled, it does not pulse.
- R7: A reload-byte write while a timer runs does not disturb the countdown in progress. It takes effect from the next reload onward.
- R8: The write that sets bit 7 of a disabled timer loads its counter from the reload byte. With the clock as source and reload B, the first pulse is visible B+2 cycles after the first falling edge that follows the capturing edge.
- R9: Rewriting the control byte of a running timer with bit 7 still set neither reloads the counter nor shifts the pulse phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register byte address |
| wr_data | input | 8 | Register write data |
| uflow | output | 4 | One-cycle underflow pulse per timer (bit 2 and bit 3 are the channel ticks) |

## Verification
The hardest behaviour to reach from the ports is the exact timing of a reload-byte change or a control rewrite in the middle of a countdown. Only the pulse spacing shows it, and only if the write lands at a known cycle inside the interval. The bench therefore synchronises on an observed pulse, issues the write a fixed number of cycles later, and measures the current interval and the following one separately. Cascaded periods are measured after one discarded interval, because the phase of the prescaler against the divisor timer is arbitrary when both start.

// File: rtl/baud_tmr_pkg.sv
`timescale 1ns/1ps
package baud_tmr_pkg;
   // count-source encodings held in control bits [3:2]
   typedef enum logic [1:0] {
      SRC_CLK   = 2'b00,
      SRC_CHAIN = 2'b01,
      SRC_RSV_A = 2'b10,
      SRC_RSV_B = 2'b11
   } tmr_src_e;

   localparam int CTL_EN_BIT  = 7;
   localparam int CTL_SRC_LSB = 2;
endpackage

// File: rtl/baud_tmr_regs.sv
`timescale 1ns/1ps
module baud_tmr_regs #(
   parameter int N_TMR    = 4,
   parameter int CNT_W    = 8,
   parameter int ADDR_W   = 5,
   parameter int CTL_OFS  = 'h00,
   parameter int LOAD_OFS = 'h10
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [CNT_W-1:0]              wr_data,
   output logic [N_TMR-1:0][CNT_W-1:0]   ctl_o,
   output logic [N_TMR-1:0][CNT_W-1:0]   load_o
);
   for (genvar i = 0; i < N_TMR; i++) begin : g_reg
      localparam logic [ADDR_W-1:0] CTL_A  = ADDR_W'(CTL_OFS + i);
      localparam logic [ADDR_W-1:0] LOAD_A = ADDR_W'(LOAD_OFS + i);
      logic [CNT_W-1:0] ctl_q, load_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ctl_q  <= '0;
            load_q <= '0;
         end else if (wr_en) begin
            if (wr_addr == CTL_A)  ctl_q  <= wr_data;
            if (wr_addr == LOAD_A) load_q <= wr_data;
         end
      end

      assign ctl_o[i]  = ctl_q;
      assign load_o[i] = load_q;
   end
endmodule

// File: rtl/baud_tmr_cell.sv
`timescale 1ns/1ps
module baud_tmr_cell
   import baud_tmr_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter bit CHAIN_OK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  tmr_src_e         src,
   input  logic [CNT_W-1:0] reload,
   input  logic             chain_evt,
   output logic             uflow_o
);
   logic             evt;
   logic             en_d_q;
   logic             uflow_q;
   logic [CNT_W-1:0] cnt_q;
   logic             start;

   if (CHAIN_OK) begin : g_sel
      always_comb begin
         unique case (src)
            SRC_CLK:   evt = 1'b1;
            SRC_CHAIN: evt = chain_evt;
            default:   evt = 1'b0;
         endcase
      end
   end else begin : g_fixed
      logic unused_sel;
      assign unused_sel = ^{src, chain_evt};
      assign evt = 1'b1;
   end

   assign start = en & ~en_d_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_d_q  <= 1'b0;
         uflow_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         en_d_q  <= en;
         uflow_q <= 1'b0;
         if (start) begin
            cnt_q <= reload;
         end else if (en && evt) begin
            if (cnt_q == '0) begin
               cnt_q   <= reload;
               uflow_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   assign uflow_o = uflow_q;
endmodule

// File: rtl/baud_tick_gen.sv
`timescale 1ns/1ps
module baud_tick_gen
   import baud_tmr_pkg::*;
#(
   parameter int N_TMR    = 4,
   parameter int CNT_W    = 8,
   parameter int ADDR_W   = 5,
   parameter int CTL_OFS  = 'h00,
   parameter int LOAD_OFS = 'h10,
   parameter int PRE_IDX  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [N_TMR-1:0]  uflow
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   if (CNT_W < 8) begin : g_bad_width
      $error("control byte needs at least 8 bits");
   end
   if (PRE_IDX >= N_TMR) begin : g_bad_pre
      $error("prescaler index out of range");
   end
   if (LOAD_OFS - CTL_OFS < N_TMR || LOAD_OFS + N_TMR > ADDR_SPAN) begin : g_bad_map
      $error("register windows overlap or exceed the address space");
   end

   logic [N_TMR-1:0][CNT_W-1:0] ctl;
   logic [N_TMR-1:0][CNT_W-1:0] load;
   logic [N_TMR-1:0]            en_vec;
   logic [N_TMR-1:0]            cas_vec;
   logic [N_TMR-1:0]            stall_vec;

   baud_tmr_regs #(
      .N_TMR(N_TMR), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
      .CTL_OFS(CTL_OFS), .LOAD_OFS(LOAD_OFS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ctl_o(ctl), .load_o(load)
   );

   for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
      tmr_src_e src;
      logic     unused_ctl;
      assign src          = tmr_src_e'(ctl[i][CTL_SRC_LSB +: 2]);
      assign en_vec[i]    = ctl[i][CTL_EN_BIT];
      assign cas_vec[i]   = (i != PRE_IDX) && (src == SRC_CHAIN);
      assign stall_vec[i] = (i != PRE_IDX) && (src == SRC_RSV_A || src == SRC_RSV_B);
      assign unused_ctl   = ^{ctl[i][CNT_W-1:CTL_EN_BIT+1], ctl[i][CTL_EN_BIT-1:CTL_SRC_LSB+2],
                              ctl[i][CTL_SRC_LSB-1:0]};

      baud_tmr_cell #(
         .CNT_W(CNT_W), .CHAIN_OK(i != PRE_IDX)
      ) u_cell (
         .clk(clk), .rst_n(rst_n), .en(en_vec[i]), .src(src),
         .reload(load[i]), .chain_evt(uflow[PRE_IDX]), .uflow_o(uflow[i])
      );
   end
endmodule

// File: rtl/baud_tick_chk.sv
`timescale 1ns/1ps
module baud_tick_chk #(
   parameter int N_TMR   = 4,
   parameter int PRE_IDX = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_TMR-1:0] uflow,
   input logic [N_TMR-1:0] en_vec,
   input logic [N_TMR-1:0] cas_vec,
   input logic [N_TMR-1:0] stall_vec
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (uflow == '0));

   for (genvar i = 0; i < N_TMR; i++) begin : g_chk
      // R3
      disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         uflow[i] |-> $past(en_vec[i]));

      // R4
      reserved_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         uflow[i] |-> !$past(stall_vec[i]));

      // R6
      chain_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (uflow[i] && $past(cas_vec[i])) |-> $past(uflow[PRE_IDX]));

      // R8
      start_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(en_vec[i]) |-> !uflow[i]);
   end
endmodule

bind baud_tick_gen baud_tick_chk #(.N_TMR(N_TMR), .PRE_IDX(PRE_IDX)) i_chk (
   .clk(clk), .rst_n(rst_n), .uflow(uflow), .en_vec(en_vec),
   .cas_vec(cas_vec), .stall_vec(stall_vec)
);

// File: tb/test_baud_tick_gen.sv
`timescale 1ns/1ps
module test_baud_tick_gen;
   localparam int LIMIT = 6000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [4:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [3:0] uflow;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   baud_tick_gen i_baud_tick_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .uflow(uflow)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic interval(input int idx, output int cyc);
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (!uflow[idx] && cyc < LIMIT);
   endtask

   task automatic measure(input string req, input int idx, input int exp);
      int c;
      interval(idx, c);
      interval(idx, c);
      interval(idx, c);
      chk(req, c, exp);
      interval(idx, c);
      chk(req, c, exp);
   endtask

   task automatic quiet(input string req, input int idx, input int cycles);
      int hits = 0;
      repeat (cycles) begin
         @(negedge clk);
         if (uflow[idx]) hits++;
      end
      chk(req, hits, 0);
   endtask

   task automatic stop_all();
      for (int t = 0; t < 4; t++) wr(5'(t), 8'h00);
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int c;
      int seen;
      int dlist[8] = '{0, 1, 2, 3, 7, 15, 100, 255};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: outputs low after reset
      seen = 0;
      repeat (20) begin @(negedge clk); seen |= int'(uflow); end
      chk("R1 reset quiet", seen, 0);

      // R5: clock-sourced sweep on channel 0 timer, R2 addresses 0x02/0x12
      foreach (dlist[k]) begin
         wr(5'h02, 8'h00);
         wr(5'h12, 8'(dlist[k]));
         wr(5'h02, 8'h80);
         measure("R5 clock period", 2, dlist[k] + 1);
      end
      // R2: timer 1 and timer 3 at their own addresses
      wr(5'h13, 8'd6); wr(5'h03, 8'h80);
      measure("R2 timer3 period", 3, 7);
      wr(5'h11, 8'd11); wr(5'h01, 8'h80);
      measure("R2 timer1 period", 1, 12);
      stop_all();

      // R6: cascade sweep, P and D over 0..3, plus larger corners
      for (int p = 0; p < 6; p++) begin
         for (int d = 0; d < 4; d++) begin
            int pv = (p < 4) ? p : ((p == 4) ? 15 : 255);
            int dv = (p < 4) ? d : ((p == 4) ? 15 : 3);
            if (p >= 4 && d > 0) continue;
            stop_all();
            wr(5'h10, 8'(pv));
            wr(5'h12, 8'(dv));
            wr(5'h00, 8'h80);
            wr(5'h02, 8'h84);
            measure("R6 cascade period", 2, (pv + 1) * (dv + 1));
         end
      end
      // R5: prescaler alone, period P+1
      stop_all();
      wr(5'h10, 8'd5); wr(5'h00, 8'h80);
      measure("R5 prescaler period", 0, 6);
      // R4: timer 0 ignores source field
      wr(5'h00, 8'h84);
      measure("R4 timer0 ignores select", 0, 6);

      // R6: prescaler disabled -> cascaded timer silent
      stop_all();
      wr(5'h12, 8'd0); wr(5'h10, 8'd0); wr(5'h02, 8'h84);
      quiet("R6 chain with prescaler off", 2, 300);

      // R4: reserved sources count nothing
      stop_all();
      wr(5'h13, 8'd0); wr(5'h03, 8'h88);
      quiet("R4 reserved 10", 3, 200);
      wr(5'h03, 8'h00); wr(5'h03, 8'h8C);
      quiet("R4 reserved 11", 3, 200);

      // R3: disabled timer silent although source and reload valid
      stop_all();
      wr(5'h12, 8'd0); wr(5'h02, 8'h00);
      quiet("R3 disabled", 2, 300);

      // R8: first pulse latency after enabling
      stop_all();
      wr(5'h12, 8'd4);
      wr(5'h02, 8'h80);
      interval(2, c);
      chk("R8 first pulse latency", c, 6);
      stop_all();
      wr(5'h12, 8'd20);
      wr(5'h02, 8'h80);
      interval(2, c);
      chk("R8 first pulse latency", c, 22);

      // R7: reload change applies from the next reload
      stop_all();
      wr(5'h12, 8'd9); wr(5'h02, 8'h80);
      interval(2, c);
      wr(5'h12, 8'd3);
      interval(2, c);
      chk("R7 current interval kept", c + 1, 10);
      interval(2, c);
      chk("R7 new reload used", c, 4);

      // R9: control rewrite with enable kept does not restart
      wr(5'h12, 8'd9);
      interval(2, c);
      interval(2, c);
      repeat (3) @(negedge clk);
      wr(5'h02, 8'h80);
      interval(2, c);
      chk("R9 rewrite keeps phase", c + 4, 10);

      // R2: writes outside both windows change nothing
      interval(2, c);
      wr(5'h06, 8'h00);
      wr(5'h16, 8'h00);
      wr(5'h0A, 8'h00);
      interval(2, c);
      chk("R2 stray address", c + 3, 10);
      interval(2, c);
      chk("R2 stray address", c, 10);

      finish_run();
   end
endmodule